// File: doc/BRIEF.md
# Paged Address Breakpoint Comparator

This block is one address comparator inside an on-chip debug unit. On every bus cycle it compares the CPU's 16-bit logical address against a value stored in three byte-wide configuration registers. Depending on the operating mode, it can also compare the upper bits of the extended paged address. It produces a registered match pulse. The debug logic around it uses this pulse as a breakpoint or trigger source.

A mode input selects between breakpoint mode and debug mode. A flag from the address decoder marks accesses that fall in program flash or ROM space. Together with a two-bit page-select field, these decide which address bits take part in the compare. They also decide which of those bits the six-bit extended field checks. All bits that are not selected are ignored.

Top module: `pac_top`

## Requirements
- R1: After a synchronous reset, all three registers read 0x00 and `hit` is 0.
- R2: Register map on `reg_addr`:
  - 0 holds the extended register, with page-select in bits 7:6 and the extended compare field in bits 5:0.
  - 1 holds the compare-high byte.
  - 2 holds the compare-low byte.
  - 3 reads 0x00 and ignores writes.
  - Writes take effect at the clock edge. `reg_rdata` shows the selected register combinationally.
- R3: When `mode_dbg`=0 and `flash_acc`=1, extended field bits 5:0 must equal extended address bits 19:14 (`ext_addr[5:0]`), and high bits 5:0 must equal `log_addr[13:8]`.
- R4: When `mode_dbg`=0 and `flash_acc`=0, the extended field is not compared, and the full high byte must equal `log_addr[15:8]`.
- R5: When `mode_dbg`=1 and page-select bit 6 is 0, the extended field is not compared, and the high byte must equal `log_addr[15:8]`.
- R6: When `mode_dbg`=1 and page-select bit 6 is 1, extended field bits 5:0 must equal extended address bits 21:16 (`ext_addr[7:2]`). The high byte must equal {`ext_addr[1:0]`, `log_addr[13:8]`}.
- R7: Page-select bit 7 has no effect on matching. Value 10 matches exactly as 00, and 11 matches exactly as 01. Reads still return the stored bit.
- R8: The low byte must equal `log_addr[7:0]` in every mode.
- R9: `hit` is 1 for exactly the clock after a cycle in which `bus_valid`=1, `enable`=1 and every selected field matched, and is 0 otherwise.
- R10: Bits that are excluded from the compare have no effect on `hit`. These are:
  - `log_addr[15:14]` in R3 and R6.
  - `ext_addr` in R4 and R5, and `ext_addr[7:6]` in R3.
  - `flash_acc` in debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| enable | input | 1 | Comparator enable |
| mode_dbg | input | 1 | 0 = breakpoint mode, 1 = debug mode |
| flash_acc | input | 1 | Current access targets flash or ROM space |
| bus_valid | input | 1 | Bus cycle valid strobe |
| log_addr | input | 16 | Logical bus address |
| ext_addr | input | 8 | Extended address bits 21:14 |
| hit | output | 1 | Registered match pulse |

## Verification
A corrupted register value shows up immediately on `reg_rdata` when that register is selected. A wrong compare selection shows up as a wrong `hit` one clock after the bus cycle that exposes it. The reference model is evaluated every cycle across random modes, flags and addresses. Directed cycles flip each excluded bit and each aliased page-select value. A mistake in bit routing or in alias decoding therefore produces a mismatch within the first cycle that exercises it.

// File: rtl/pac_pkg.sv
package pac_pkg;
    localparam int LA_W   = 16;
    localparam int XA_W   = 8;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int EXT_W  = BYTE_W - SEL_W;
    localparam int RA_W   = 2;
    localparam int PG_W   = LA_W - BYTE_W - EXT_W;

    typedef enum logic {MODE_BKP = 1'b0, MODE_DBG = 1'b1} cmp_mode_e;
    typedef enum logic [RA_W-1:0] {
        RA_EXT = 2'd0, RA_HI = 2'd1, RA_LO = 2'd2, RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0]  pg_sel;
        logic [EXT_W-1:0]  ext;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cmp_cfg_t;

    typedef struct packed {
        logic ext_ok;
        logic hi_ok;
        logic lo_ok;
    } cmp_vote_t;

    // Only the low page-select bit is decoded; the upper bit aliases.
    function automatic logic paged_sel(input logic [SEL_W-1:0] sel);
        return sel[0];
    endfunction
endpackage

// File: rtl/pac_regs.sv
module pac_regs
    import pac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_we,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output cmp_cfg_t          cfg
);
    localparam int NREG = 3;
    logic [BYTE_W-1:0] bank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank[i] <= '0;
            else if (reg_we && reg_addr == RA_W'(i))
                bank[i] <= reg_wdata;
        end
    end

    assign cfg.pg_sel = bank[RA_EXT][BYTE_W-1 -: SEL_W];
    assign cfg.ext    = bank[RA_EXT][EXT_W-1:0];
    assign cfg.hi     = bank[RA_HI];
    assign cfg.lo     = bank[RA_LO];

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_EXT:  reg_rdata = bank[RA_EXT];
            RA_HI:   reg_rdata = bank[RA_HI];
            RA_LO:   reg_rdata = bank[RA_LO];
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pac_match.sv
module pac_match
    import pac_pkg::*;
(
    input  cmp_cfg_t        cfg,
    input  cmp_mode_e       mode,
    input  logic            flash_acc,
    input  logic [LA_W-1:0] log_addr,
    input  logic [XA_W-1:0] ext_addr,
    output cmp_vote_t       vote
);
    logic [BYTE_W-1:0] hi_tgt;
    logic [EXT_W-1:0]  ext_tgt;
    logic              ext_use;
    logic              hi_narrow;

    always_comb begin
        ext_use   = 1'b0;
        hi_narrow = 1'b0;
        ext_tgt   = ext_addr[EXT_W-1:0];
        hi_tgt    = log_addr[LA_W-1 -: BYTE_W];
        if (mode == MODE_BKP) begin
            if (flash_acc) begin
                ext_use   = 1'b1;
                hi_narrow = 1'b1;
            end
        end else if (paged_sel(cfg.pg_sel)) begin
            ext_use = 1'b1;
            ext_tgt = ext_addr[XA_W-1 -: EXT_W];
            hi_tgt  = {ext_addr[PG_W-1:0], log_addr[LA_W-PG_W-1:BYTE_W]};
        end
    end

    always_comb begin
        vote.ext_ok = !ext_use || (cfg.ext == ext_tgt);
        if (hi_narrow)
            vote.hi_ok = (cfg.hi[EXT_W-1:0] == hi_tgt[EXT_W-1:0]);
        else
            vote.hi_ok = (cfg.hi == hi_tgt);
        vote.lo_ok = (cfg.lo == log_addr[BYTE_W-1:0]);
    end
endmodule

// File: rtl/pac_top.sv
module pac_top
    import pac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_we,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              enable,
    input  logic              mode_dbg,
    input  logic              flash_acc,
    input  logic              bus_valid,
    input  logic [LA_W-1:0]   log_addr,
    input  logic [XA_W-1:0]   ext_addr,
    output logic              hit
);
    cmp_cfg_t  cfg;
    cmp_vote_t vote;

    pac_regs u_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg)
    );

    pac_match u_match (
        .cfg(cfg), .mode(cmp_mode_e'(mode_dbg)), .flash_acc(flash_acc),
        .log_addr(log_addr), .ext_addr(ext_addr), .vote(vote)
    );

    always_ff @(posedge clk) begin
        if (rst)
            hit <= 1'b0;
        else
            hit <= bus_valid && enable && (&vote);
    end
endmodule

// File: rtl/pac_chk.sv
module pac_chk
    import pac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [RA_W-1:0]   reg_addr,
    input logic              reg_we,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              enable,
    input logic              bus_valid,
    input logic [LA_W-1:0]   log_addr,
    input logic              hit
);
    logic [BYTE_W-1:0] sh_ext, sh_hi, sh_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_ext <= '0; sh_hi <= '0; sh_lo <= '0;
        end else if (reg_we) begin
            if (reg_addr == 2'd0) sh_ext <= reg_wdata;
            if (reg_addr == 2'd1) sh_hi  <= reg_wdata;
            if (reg_addr == 2'd2) sh_lo  <= reg_wdata;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit);
    a_r2_read_ext: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> reg_rdata == sh_ext);
    a_r2_read_hi: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd1) |-> reg_rdata == sh_hi);
    a_r2_read_lo: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd2) |-> reg_rdata == sh_lo);
    a_r2_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd3) |-> reg_rdata == '0);
    a_r8_low_byte: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(log_addr[BYTE_W-1:0]) == $past(sh_lo));
    a_r9_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(bus_valid && enable));
endmodule

bind pac_top pac_chk u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .enable(enable),
    .bus_valid(bus_valid), .log_addr(log_addr), .hit(hit)
);

// File: tb/sim_pac_top.sv
`timescale 1ns/1ps
module sim_pac_top;
    logic clk = 0, rst = 1;
    logic [1:0] reg_addr = 0;
    logic reg_we = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic enable = 0, mode_dbg = 0, flash_acc = 0, bus_valid = 0;
    logic [15:0] log_addr = 0;
    logic [7:0] ext_addr = 0;
    logic hit;
    int checks = 0, errors = 0;
    logic [7:0] m_ext = 0, m_hi = 0, m_lo = 0;

    always #5 clk = ~clk;

    pac_top u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .enable(enable),
        .mode_dbg(mode_dbg), .flash_acc(flash_acc), .bus_valid(bus_valid),
        .log_addr(log_addr), .ext_addr(ext_addr), .hit(hit)
    );

    function automatic bit ref_hit(bit m, bit f, logic [7:0] er, logic [7:0] h,
                                   logic [7:0] l, logic [15:0] la,
                                   logic [7:0] xa, bit v, bit e);
        logic [21:0] full;
        full = {xa, la[13:0]};
        if (!v || !e) return 0;
        if (la[7:0] != l) return 0;
        if (!m) begin
            if (f) return (er[5:0] == full[19:14]) && (h[5:0] == la[13:8]);
            return h == la[15:8];
        end
        if (!er[6]) return h == la[15:8];
        return (er[5:0] == full[21:16]) && (h == {full[15:14], la[13:8]});
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_we = 1; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        case (a)
            2'd0: m_ext = d;
            2'd1: m_hi = d;
            2'd2: m_lo = d;
            default: ;
        endcase
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Drive one bus cycle; check hit one clock later against both the
    // explicit expectation and the reference model.
    task automatic bus(input string tag, input bit m, input bit f,
                       input logic [15:0] la, input logic [7:0] xa,
                       input bit v, input bit e, input bit exp);
        bit mdl;
        mode_dbg = m; flash_acc = f; log_addr = la; ext_addr = xa;
        bus_valid = v; enable = e;
        mdl = ref_hit(m, f, m_ext, m_hi, m_lo, la, xa, v, e);
        @(negedge clk);
        bus_valid = 0;
        chk(tag, {7'd0, hit}, {7'd0, exp});
        chk({tag, "_model"}, {7'd0, hit}, {7'd0, mdl});
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd("R1_ext", 2'd0, 8'h00);
        rd("R1_hi", 2'd1, 8'h00);
        rd("R1_lo", 2'd2, 8'h00);
        chk("R1_hit", {7'd0, hit}, 8'h00);

        // R2 register map
        wr(2'd0, 8'h2A); wr(2'd1, 8'hC5); wr(2'd2, 8'h3C);
        wr(2'd3, 8'hFF);
        rd("R2_ext", 2'd0, 8'h2A);
        rd("R2_hi", 2'd1, 8'hC5);
        rd("R2_lo", 2'd2, 8'h3C);
        rd("R2_hole", 2'd3, 8'h00);

        // R3 breakpoint mode, flash access
        bus("R3_match", 0, 1, 16'h053C, 8'h2A, 1, 1, 1);
        bus("R3_ext_miss", 0, 1, 16'h053C, 8'h2B, 1, 1, 0);
        bus("R3_hi_miss", 0, 1, 16'h063C, 8'h2A, 1, 1, 0);
        bus("R10_bkp_flash_excl", 0, 1, 16'hC53C, 8'hEA, 1, 1, 1);
        // R4 breakpoint mode, other space
        bus("R4_match", 0, 0, 16'hC53C, 8'h00, 1, 1, 1);
        bus("R4_hi_top_miss", 0, 0, 16'h053C, 8'h2A, 1, 1, 0);
        bus("R10_bkp_ext_excl", 0, 0, 16'hC53C, 8'hFF, 1, 1, 1);
        // R5 debug mode, page-select 00
        bus("R5_match", 1, 1, 16'hC53C, 8'h55, 1, 1, 1);
        bus("R5_miss", 1, 0, 16'h053C, 8'h2A, 1, 1, 0);
        bus("R10_dbg_flash_excl", 1, 0, 16'hC53C, 8'h55, 1, 1, 1);
        // R8 low byte in each mode
        bus("R8_bkp", 0, 1, 16'h053D, 8'h2A, 1, 1, 0);
        bus("R8_dbg", 1, 0, 16'hC53D, 8'h00, 1, 1, 0);

        // R6 debug mode, page-select 01
        wr(2'd0, 8'h6A);
        bus("R6_match", 1, 1, 16'h053C, 8'hAB, 1, 1, 1);
        bus("R10_dbg_pg_excl", 1, 0, 16'hC53C, 8'hAB, 1, 1, 1);
        bus("R6_ext_miss", 1, 1, 16'h053C, 8'hAF, 1, 1, 0);
        bus("R6_pg_miss", 1, 1, 16'h053C, 8'hA8, 1, 1, 0);
        bus("R6_low6_miss", 1, 1, 16'h043C, 8'hAB, 1, 1, 0);

        // R7 alias of page-select bit 7
        wr(2'd0, 8'hEA);
        rd("R7_read11", 2'd0, 8'hEA);
        bus("R7_sel11_as01", 1, 1, 16'h053C, 8'hAB, 1, 1, 1);
        wr(2'd0, 8'hAA);
        rd("R7_read10", 2'd0, 8'hAA);
        bus("R7_sel10_as00", 1, 1, 16'hC53C, 8'h00, 1, 1, 1);
        bus("R7_sel10_not01", 1, 1, 16'h053C, 8'hAB, 1, 1, 0);

        // R9 strobe, enable and timing
        bus("R9_no_valid", 1, 1, 16'hC53C, 8'h00, 0, 1, 0);
        bus("R9_no_enable", 1, 1, 16'hC53C, 8'h00, 1, 0, 0);
        mode_dbg = 1; log_addr = 16'hC53C; bus_valid = 1; enable = 1;
        #1 chk("R9_not_early", {7'd0, hit}, 8'h00);
        @(negedge clk);
        bus_valid = 0;
        chk("R9_one_later", {7'd0, hit}, 8'h01);
        @(negedge clk);
        chk("R9_single_pulse", {7'd0, hit}, 8'h00);

        // Random sweep against the reference model (R3 R4 R5 R6 R10)
        for (int i = 0; i < 400; i++) begin
            logic [15:0] la;
            logic [7:0] xa;
            bit mm, ff, ee;
            if (i % 50 == 0) begin
                wr(2'd0, 8'($urandom)); wr(2'd1, 8'($urandom)); wr(2'd2, 8'($urandom));
            end
            mm = 1'($urandom); ff = 1'($urandom); ee = ($urandom % 8) != 0;
            la = {m_hi, m_lo}; xa = {m_ext[5:0], m_hi[7:6]};
            if (!mm && ff) xa = {2'($urandom), m_ext[5:0]};
            if ($urandom % 4 == 0) la = 16'($urandom);
            if ($urandom % 3 == 0) la[15:14] = 2'($urandom);
            mode_dbg = mm; flash_acc = ff; log_addr = la; ext_addr = xa;
            bus_valid = 1'($urandom); enable = ee;
            begin
                bit mdl;
                mdl = ref_hit(mm, ff, m_ext, m_hi, m_lo, la, xa, bus_valid, ee);
                @(negedge clk);
                chk("R10_random_model", {7'd0, hit}, {7'd0, mdl});
            end
        end

        // R1 reset clears registers again
        rst = 1; @(negedge clk); rst = 0;
        m_ext = 0; m_hi = 0; m_lo = 0;
        rd("R1_reset2_hi", 2'd1, 8'h00);
        chk("R1_reset2_hit", {7'd0, hit}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule